// File: doc/BRIEF.md
# I2C Master Arbitration Loss Detector

This block sits beside the byte engine of an I2C controller that shares its bus with other masters. While the local controller is master and transmitter, the block compares the SDA level the controller intends to drive with the level seen on the bus. It makes this comparison at each rising edge of SCL, and only for address and data bits.

Another master can pull SDA low while the local side releases it (drives a 1). When that happens, the block raises a sticky arbitration-lost flag and drops the mode to slave receiver. It then forces both SDA and SCL drive values to the released (high) level, so the local side neither disturbs the winning transfer nor clocks the rest of its byte. The flag stays set until software reads or writes the data buffer, or writes the control register.

Top module: `i2c_arb_monitor`

## Requirements
- R1: SCL and SDA pass through SYNC_STAGES (default 2) flip-flops each. A rising edge of SCL is detected from the synchronised value. With default parameters, a loss caused by an SCL rise shows on `arb_lost` at the third clock edge after the rise, and not before.
- R2: When an SCL rise is detected while mst=1, trx=1 and bit_is_ack=0, a loss is recorded if `sda_drv`=1 and the synchronised bus SDA is 0. `arb_lost` then goes to 1.
- R3: The clock edge that sets `arb_lost` also clears `mst` and `trx` to 0, which is slave receiver mode.
- R4: While `arb_lost`=1, `scl_out` is 1 whatever `scl_drv` is.
- R5: While `arb_lost`=1, `sda_out` is 1 whatever `sda_drv` is. Otherwise `sda_out` and `scl_out` take `sda_drv` and `scl_drv` one clock later.
- R6: A one-cycle pulse on `dbr_wr`, `dbr_rd` or `cr2_wr` clears `arb_lost` at the next clock edge.
- R7: A driven 0 with the bus at 1 is not a loss, because the local side is then pulling low and the bus reading is not compared against it.
- R8: No loss is recorded during the acknowledge slot (bit_is_ack=1), or when mst=0 or trx=0.
- R9: When a clear strobe and a new loss fall in the same cycle, `arb_lost` is 1 after that edge.
- R10: A `cr2_wr` pulse loads `mst` and `trx` from `cr2_mst` and `cr2_trx`, unless a loss occurs in the same cycle.
- R11: Synchronous reset gives arb_lost=0, mst=0, trx=0, sda_out=1 and scl_out=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL level read from the bus (asynchronous) |
| sda_in | input | 1 | SDA level read from the bus (asynchronous) |
| sda_drv | input | 1 | SDA value the controller wants to drive (1 = release) |
| scl_drv | input | 1 | SCL value the controller wants to drive (1 = release) |
| bit_is_ack | input | 1 | High while the current bit is the acknowledge slot |
| dbr_wr | input | 1 | Software write strobe to the data buffer |
| dbr_rd | input | 1 | Software read strobe from the data buffer |
| cr2_wr | input | 1 | Software write strobe to the control register |
| cr2_mst | input | 1 | Master bit written with cr2_wr |
| cr2_trx | input | 1 | Transmitter bit written with cr2_wr |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| mst | output | 1 | Current master bit |
| trx | output | 1 | Current transmitter bit |
| sda_out | output | 1 | Gated SDA drive value |
| scl_out | output | 1 | Gated SCL drive value |

## Verification
A bus change reaches the comparator after two synchroniser edges. The flag and mode bits then update at the third edge. The bench therefore waits three rising clock edges after raising `scl_in` and samples on the following falling edge; for R1 it also samples once after only two edges. Strobes and the drive inputs act through a single register, so their effects are read one clock edge after the strobe. For R9, the clear strobe is placed in the cycle between the second and third edges, which is the cycle in which the comparison is made.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;
  typedef struct packed {
    logic mst;
    logic trx;
  } arb_mode_t;

  localparam arb_mode_t MODE_SLAVE_RX = '{mst: 1'b0, trx: 1'b0};
endpackage

// File: rtl/i2c_arb_sync.sv
module i2c_arb_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain_q[i] <= '1;
        else     chain_q[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain_q[i] <= '1;
        else     chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_arb_cmp.sv
module i2c_arb_cmp
  import i2c_arb_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      scl_s,
  input  logic      sda_s,
  input  logic      sda_drv,
  input  logic      bit_is_ack,
  input  arb_mode_t mode,
  output logic      loss
);
  logic scl_prev_q;
  logic scl_rise;
  logic compare_en;

  always_ff @(posedge clk) begin
    if (rst) scl_prev_q <= 1'b1;
    else     scl_prev_q <= scl_s;
  end

  assign scl_rise   = scl_s & ~scl_prev_q;
  assign compare_en = scl_rise & mode.mst & mode.trx & ~bit_is_ack;
  // Open drain: only a released line seen low means another master won.
  assign loss       = compare_en & sda_drv & ~sda_s;

  // R1: a detected rise lasts a single cycle
  a_r1_single_rise: assert property (@(posedge clk) disable iff (rst)
    scl_rise |=> !scl_rise);
endmodule

// File: rtl/i2c_arb_state.sv
module i2c_arb_state
  import i2c_arb_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      loss,
  input  logic      clr,
  input  logic      mode_wr,
  input  arb_mode_t mode_wdata,
  input  logic      sda_drv,
  input  logic      scl_drv,
  output logic      lost,
  output arb_mode_t mode,
  output logic      sda_out,
  output logic      scl_out
);
  logic      lost_n;
  arb_mode_t mode_n;

  always_comb begin
    lost_n = lost;
    if (clr)  lost_n = 1'b0;
    if (loss) lost_n = 1'b1;
    mode_n = mode;
    if (mode_wr) mode_n = mode_wdata;
    if (loss)    mode_n = MODE_SLAVE_RX;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lost    <= 1'b0;
      mode    <= MODE_SLAVE_RX;
      sda_out <= 1'b1;
      scl_out <= 1'b1;
    end else begin
      lost    <= lost_n;
      mode    <= mode_n;
      sda_out <= lost_n | sda_drv;
      scl_out <= lost_n | scl_drv;
    end
  end

  a_r2_loss_sets_flag: assert property (@(posedge clk) disable iff (rst)
    loss |=> lost);
  a_r3_mode_dropped: assert property (@(posedge clk) disable iff (rst)
    $rose(lost) |-> (!mode.mst && !mode.trx));
  a_r4_scl_released: assert property (@(posedge clk) disable iff (rst)
    lost |-> scl_out);
  a_r5_sda_released: assert property (@(posedge clk) disable iff (rst)
    lost |-> sda_out);
  a_r6_access_clears: assert property (@(posedge clk) disable iff (rst)
    (clr && !loss) |=> !lost);
  a_r9_loss_wins: assert property (@(posedge clk) disable iff (rst)
    (clr && loss) |=> lost);
  a_r10_mode_load: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && !loss) |=> (mode == $past(mode_wdata)));
endmodule

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor
  import i2c_arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  input  logic sda_drv,
  input  logic scl_drv,
  input  logic bit_is_ack,
  input  logic dbr_wr,
  input  logic dbr_rd,
  input  logic cr2_wr,
  input  logic cr2_mst,
  input  logic cr2_trx,
  output logic arb_lost,
  output logic mst,
  output logic trx,
  output logic sda_out,
  output logic scl_out
);
  localparam int BUS_W = 2;

  logic [BUS_W-1:0] bus_s;
  logic             loss;
  logic             clr;
  arb_mode_t        mode;
  arb_mode_t        mode_wdata;

  i2c_arb_sync #(.STAGES(SYNC_STAGES), .WIDTH(BUS_W)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_in, sda_in}),
    .q   (bus_s)
  );

  i2c_arb_cmp u_cmp (
    .clk        (clk),
    .rst        (rst),
    .scl_s      (bus_s[1]),
    .sda_s      (bus_s[0]),
    .sda_drv    (sda_drv),
    .bit_is_ack (bit_is_ack),
    .mode       (mode),
    .loss       (loss)
  );

  assign clr        = dbr_wr | dbr_rd | cr2_wr;
  assign mode_wdata = '{mst: cr2_mst, trx: cr2_trx};

  i2c_arb_state u_state (
    .clk        (clk),
    .rst        (rst),
    .loss       (loss),
    .clr        (clr),
    .mode_wr    (cr2_wr),
    .mode_wdata (mode_wdata),
    .sda_drv    (sda_drv),
    .scl_drv    (scl_drv),
    .lost       (arb_lost),
    .mode       (mode),
    .sda_out    (sda_out),
    .scl_out    (scl_out)
  );

  assign mst = mode.mst;
  assign trx = mode.trx;
endmodule

// File: tb/tb_i2c_arb_monitor.sv
module tb_i2c_arb_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {mst, trx, ack, drv, bus, exp_lost}
  localparam logic [5:0] VEC [NVEC] = '{
    6'b110101, 6'b110110, 6'b110000, 6'b110010,
    6'b111100, 6'b010100, 6'b100100, 6'b000100
  };

  logic clk = 0, rst = 1;
  logic scl_in = 0, sda_in = 1, sda_drv = 1, scl_drv = 1, bit_is_ack = 0;
  logic dbr_wr = 0, dbr_rd = 0, cr2_wr = 0, cr2_mst = 0, cr2_trx = 0;
  logic arb_lost, mst, trx, sda_out, scl_out;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_arb_monitor dut (.*);

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_mode(logic m, logic t);
    cr2_mst = m; cr2_trx = t; cr2_wr = 1;
    cyc(1);
    cr2_wr = 0;
  endtask

  // prepare mode and bus, then raise SCL and wait for the result edge
  task automatic bit_rise(logic m, logic t, logic ack, logic drv, logic bus);
    scl_in = 0;
    cyc(4);
    load_mode(m, t);
    bit_is_ack = ack; sda_drv = drv; sda_in = bus;
    cyc(3);
    scl_in = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 0;
    // R11 reset state
    chk("R11 lost", arb_lost, 0); chk("R11 mst", mst, 0); chk("R11 trx", trx, 0);
    chk("R11 sda_out", sda_out, 1); chk("R11 scl_out", scl_out, 1);

    // table walk: R2 R3 R7 R8 R10
    for (int i = 0; i < NVEC; i++) begin
      bit_rise(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1]);
      cyc(3);
      chk("R2/R7/R8 lost", arb_lost, VEC[i][0]);
      chk("R3/R10 mst", mst, VEC[i][0] ? 1'b0 : VEC[i][5]);
      chk("R3/R10 trx", trx, VEC[i][0] ? 1'b0 : VEC[i][4]);
    end

    // R1 latency: not set after two edges, set after the third
    bit_rise(1, 1, 0, 1, 0);
    cyc(2);
    chk("R1 early", arb_lost, 0);
    cyc(1);
    chk("R1 third edge", arb_lost, 1);

    // R4 R5 outputs held released while lost
    scl_drv = 0; sda_drv = 0;
    cyc(2);
    chk("R4 scl_out", scl_out, 1);
    chk("R5 sda_out", sda_out, 1);

    // R6 clear by data read; then outputs follow drive one cycle later (R5)
    dbr_rd = 1; cyc(1); dbr_rd = 0;
    chk("R6 rd clears", arb_lost, 0);
    chk("R5 sda follows", sda_out, 0);
    chk("R4 scl follows", scl_out, 0);
    sda_drv = 1; scl_drv = 1;
    cyc(1);
    chk("R5 sda follows 1", sda_out, 1);

    // R6 clear by data write
    bit_rise(1, 1, 0, 1, 0);
    cyc(3);
    chk("R6 setup", arb_lost, 1);
    dbr_wr = 1; cyc(1); dbr_wr = 0;
    chk("R6 wr clears", arb_lost, 0);

    // R6 clear by control write, and R10 mode load
    bit_rise(1, 1, 0, 1, 0);
    cyc(3);
    load_mode(1, 0);
    chk("R6 cr2 clears", arb_lost, 0);
    chk("R10 mst", mst, 1);
    chk("R10 trx", trx, 0);

    // R9 clear in the comparison cycle loses to new loss
    bit_rise(1, 1, 0, 1, 0);
    cyc(2);
    dbr_wr = 1; cyc(1); dbr_wr = 0;
    chk("R9 loss wins", arb_lost, 1);
    chk("R9 mst", mst, 0);

    scl_in = 0;
    cyc(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule